// File: doc/BRIEF.md
# Proportional-Integral Loop Filter with Holdover

This block is the digital loop filter of a sampled-phase PLL in which a voltage-controlled crystal oscillator is steered through a 12-bit DAC. An ADC samples the reference with a clock derived from the oscillator. Each ADC word is a signed 10-bit phase error and arrives with a valid strobe, one per loop tick (nominally 5 MHz). The filter adds three terms: a mid-scale offset, the error shifted left by a proportional gain, and a bounded up/down counter shifted left by an integral gain. It clamps the sum to the DAC range and registers it.

The integral path is a counter that moves by one step per sample according to the sign of the error. It does not accumulate the full error value, which keeps the logic small. When the reference is absent, an external hold request freezes both the counter and the DAC word. The oscillator then keeps its last control voltage. Tracking resumes from the frozen counter once the hold is released.

Top module: `pi_holdover_filter`

## Requirements
- R1: After reset, `dac_code` is 2048 (mid-scale) and the integral counter is zero.
- R2: `phase_err` is a two's-complement word. A sample is accepted when `sample_valid`=1 and `hold_req`=0 at a rising clock edge. That same edge loads `dac_code` with the clamped value 2048 + err·2^KP_SHIFT + cnt·2^KI_SHIFT, where cnt is the counter value after the same sample's step. With the defaults KP_SHIFT=1 and KI_SHIFT=2.
- R3: On an accepted sample the counter rises by one if err > 0, falls by one if err < 0, and is unchanged if err = 0.
- R4: The counter saturates at +(2^(INT_W-1)-1) and -2^(INT_W-1) (+511 and -512 by default) and never wraps.
- R5: A sum below 0 gives `dac_code` 0, and a sum above 4095 gives `dac_code` 4095.
- R6: When `sample_valid`=0, neither the counter nor `dac_code` changes, whatever `phase_err` holds.
- R7: While `hold_req`=1, `dac_code` and the counter stay at their last values. The first accepted sample after release steps from the frozen counter.
- R8: If `hold_req` and `sample_valid` are both 1 in the same cycle, the sample is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Qualifies `phase_err` for one cycle |
| phase_err | input | ERR_W (10) | Signed phase-error sample from the ADC |
| hold_req | input | 1 | Freezes the filter while the reference is missing |
| dac_code | output | DAC_W (12) | Registered oscillator control word |

## Verification
Two functions can meet in the same cycle: a valid sample arriving and the hold freezing the loop. The bench raises `hold_req` on the very cycle that a valid, large error is presented. It also keeps feeding valid samples of both signs during the hold. It judges the result by `dac_code` staying bit-identical, and by the first sample after release producing the value predicted from the pre-hold counter. The second coincidence is counter saturation together with output clamping. Long runs of one sign drive the counter into its rail while the sum also exceeds the DAC range. A later sample of opposite sign then shows that the counter neither wrapped nor kept counting past its bound.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pi_err_decode.sv
module pi_err_decode
    import pi_loop_pkg::*;
#(
    parameter int ERR_W    = 10,
    parameter int KP_SHIFT = 1,
    parameter int SUM_W    = 16
) (
    input  logic        [ERR_W-1:0] err_i,
    output step_e                   step_o,
    output logic signed [SUM_W-1:0] prop_o
);
    localparam int EXT_W = SUM_W - ERR_W;

    logic signed [SUM_W-1:0] err_ext;

    always_comb begin
        err_ext = {{EXT_W{err_i[ERR_W-1]}}, err_i};
        prop_o  = err_ext <<< KP_SHIFT;
        if (err_i == '0) begin
            step_o = STEP_NONE;
        end else if (err_i[ERR_W-1]) begin
            step_o = STEP_DOWN;
        end else begin
            step_o = STEP_UP;
        end
    end

endmodule

// File: rtl/pi_updown_cnt.sv
module pi_updown_cnt
    import pi_loop_pkg::*;
#(
    parameter int INT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  step_e                   step_i,
    output logic signed [INT_W-1:0] cnt_o,
    output logic signed [INT_W-1:0] cnt_next_o
);
    localparam logic signed [INT_W-1:0] CNT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] CNT_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic signed [INT_W-1:0] ONE     = {{(INT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic signed [INT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_i) begin
            unique case (step_i)
                STEP_UP: begin
                    if (state_q.cnt != CNT_MAX) state_d.cnt = state_q.cnt + ONE;
                end
                STEP_DOWN: begin
                    if (state_q.cnt != CNT_MIN) state_d.cnt = state_q.cnt - ONE;
                end
                default: state_d.cnt = state_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o      = state_q.cnt;
    assign cnt_next_o = state_d.cnt;

endmodule

// File: rtl/pi_out_clamp.sv
module pi_out_clamp #(
    parameter int INT_W    = 10,
    parameter int KI_SHIFT = 2,
    parameter int DAC_W    = 12,
    parameter int SUM_W    = 16
) (
    input  logic signed [SUM_W-1:0] prop_i,
    input  logic signed [INT_W-1:0] integ_i,
    output logic        [DAC_W-1:0] code_o
);
    localparam int EXT_W = SUM_W - INT_W;
    localparam logic signed [SUM_W-1:0] MID_SCALE =
        {{(SUM_W-DAC_W){1'b0}}, 1'b1, {(DAC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] TOP_CODE =
        {{(SUM_W-DAC_W){1'b0}}, {DAC_W{1'b1}}};

    logic signed [SUM_W-1:0] integ_ext;
    logic signed [SUM_W-1:0] integ_term;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        integ_ext  = {{EXT_W{integ_i[INT_W-1]}}, integ_i};
        integ_term = integ_ext <<< KI_SHIFT;
        sum        = MID_SCALE + prop_i + integ_term;
        if (sum[SUM_W-1]) begin
            code_o = '0;
        end else if (sum > TOP_CODE) begin
            code_o = '1;
        end else begin
            code_o = sum[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/pi_holdover_filter.sv
module pi_holdover_filter
    import pi_loop_pkg::*;
#(
    parameter int ERR_W    = 10,
    parameter int DAC_W    = 12,
    parameter int INT_W    = 10,
    parameter int KP_SHIFT = 1,
    parameter int KI_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [ERR_W-1:0] phase_err,
    input  logic             hold_req,
    output logic [DAC_W-1:0] dac_code
);
    localparam int SUM_W = max3(ERR_W + KP_SHIFT, INT_W + KI_SHIFT, DAC_W + 1) + 2;
    localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};

    typedef struct packed {
        logic [DAC_W-1:0] dac;
    } out_state_t;

    out_state_t              state_d, state_q;
    logic                    accept;
    step_e                   step;
    logic signed [SUM_W-1:0] prop_term;
    logic signed [INT_W-1:0] integ_cnt;
    logic signed [INT_W-1:0] integ_next;
    logic        [DAC_W-1:0] clamp_code;

    assign accept = sample_valid & ~hold_req;

    pi_err_decode #(
        .ERR_W    (ERR_W),
        .KP_SHIFT (KP_SHIFT),
        .SUM_W    (SUM_W)
    ) u_decode (
        .err_i  (phase_err),
        .step_o (step),
        .prop_o (prop_term)
    );

    pi_updown_cnt #(
        .INT_W (INT_W)
    ) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (accept),
        .step_i     (step),
        .cnt_o      (integ_cnt),
        .cnt_next_o (integ_next)
    );

    pi_out_clamp #(
        .INT_W    (INT_W),
        .KI_SHIFT (KI_SHIFT),
        .DAC_W    (DAC_W),
        .SUM_W    (SUM_W)
    ) u_clamp (
        .prop_i  (prop_term),
        .integ_i (integ_next),
        .code_o  (clamp_code)
    );

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.dac = clamp_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.dac <= MID_CODE;
        end else begin
            state_q <= state_d;
        end
    end

    assign dac_code = state_q.dac;

endmodule

// File: rtl/pi_holdover_checker.sv
module pi_holdover_checker #(
    parameter int ERR_W = 10,
    parameter int DAC_W = 12,
    parameter int INT_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_valid,
    input logic                    hold_req,
    input logic        [ERR_W-1:0] phase_err,
    input logic signed [INT_W-1:0] cnt,
    input logic        [DAC_W-1:0] dac_code
);
    localparam logic signed [INT_W-1:0] CNT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] CNT_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic signed [INT_W-1:0] ONE     = {{(INT_W-1){1'b0}}, 1'b1};

    logic take, err_pos, err_neg;
    assign take    = sample_valid && !hold_req;
    assign err_neg = phase_err[ERR_W-1];
    assign err_pos = !phase_err[ERR_W-1] && (phase_err != '0);

    AST_HOLD_FREEZES_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> $stable(dac_code));                                   // R7
    AST_IDLE_KEEPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(dac_code));                              // R6
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cnt));                                           // R8
    AST_CNT_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && err_pos && cnt != CNT_MAX) |=> (cnt == $past(cnt) + ONE)); // R3
    AST_CNT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && err_neg && cnt != CNT_MIN) |=> (cnt == $past(cnt) - ONE)); // R3
    AST_CNT_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (take && err_pos && cnt == CNT_MAX) |=> (cnt == CNT_MAX));          // R4
    AST_CNT_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && err_neg && cnt == CNT_MIN) |=> (cnt == CNT_MIN));          // R4

endmodule

bind pi_holdover_filter pi_holdover_checker #(
    .ERR_W (ERR_W),
    .DAC_W (DAC_W),
    .INT_W (INT_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .hold_req     (hold_req),
    .phase_err    (phase_err),
    .cnt          (integ_cnt),
    .dac_code     (dac_code)
);

// File: tb/test_pi_holdover_filter.sv
`timescale 1ns/1ps
module test_pi_holdover_filter;

    localparam int ERR_W = 10;
    localparam int DAC_W = 12;
    localparam int INT_W = 10;
    localparam int KP    = 1;
    localparam int KI    = 2;
    localparam int CMAX  = (1 << (INT_W-1)) - 1;
    localparam int CMIN  = -(1 << (INT_W-1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_valid = 1'b0;
    logic [ERR_W-1:0] phase_err = '0;
    logic             hold_req = 1'b0;
    logic [DAC_W-1:0] dac_code;

    int n_checks = 0;
    int n_errors = 0;
    int m_cnt    = 0;
    int m_dac    = 2048;

    always #2.5 clk = ~clk;

    pi_holdover_filter #(
        .ERR_W (ERR_W), .DAC_W (DAC_W), .INT_W (INT_W),
        .KP_SHIFT (KP), .KI_SHIFT (KI)
    ) i_pi_holdover_filter (
        .clk (clk), .rst_n (rst_n), .sample_valid (sample_valid),
        .phase_err (phase_err), .hold_req (hold_req), .dac_code (dac_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: dac_code actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_take(input int e);
        int s;
        if (e > 0 && m_cnt < CMAX) m_cnt++;
        if (e < 0 && m_cnt > CMIN) m_cnt--;
        s = 2048 + e * (1 << KP) + m_cnt * (1 << KI);
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        m_dac = s;
    endfunction

    // drive one cycle of stimulus, then compare at the next falling edge
    task automatic cycle(input int e, input bit v, input bit h, input string req);
        @(negedge clk);
        phase_err    = ERR_W'(e);
        sample_valid = v;
        hold_req     = h;
        @(posedge clk);
        #1;
        sample_valid = 1'b0;
        if (v && !h) model_take(e);
        @(negedge clk);
        check(req, int'(dac_code), m_dac);
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mid-scale", int'(dac_code), 2048);
        rst_n = 1'b1;
        cycle(0, 1'b1, 1'b0, "R1 zero counter after reset");

        // R2 R3 R4: sweep every error code, counter walks to the low rail and back
        for (int e = -512; e < 512; e++) cycle(e, 1'b1, 1'b0, "R2 sweep");

        // R6: unqualified samples are ignored
        cycle(400, 1'b0, 1'b0, "R6 invalid positive");
        cycle(-300, 1'b0, 1'b0, "R6 invalid negative");
        cycle(0, 1'b1, 1'b0, "R6 counter untouched");

        // R8: hold rises on the same cycle as a valid large sample
        cycle(500, 1'b1, 1'b1, "R8 hold with valid");
        cycle(-500, 1'b1, 1'b1, "R7 hold valid negative");
        cycle(77, 1'b0, 1'b1, "R7 hold idle");
        for (int i = 0; i < 20; i++) cycle(250, 1'b1, 1'b1, "R7 hold burst");
        cycle(5, 1'b1, 1'b0, "R7 resume from frozen counter");

        // R4 R5: drive to the upper rail
        for (int i = 0; i < 1100; i++) cycle(1, 1'b1, 1'b0, "R4 climb");
        check("R4 upper rail output", int'(dac_code), 2048 + 2 + CMAX * 4);
        cycle(511, 1'b1, 1'b0, "R5 clamp high");
        check("R5 clamp high value", int'(dac_code), 4095);
        cycle(-1, 1'b1, 1'b0, "R4 no wrap high");
        check("R4 step down from rail", int'(dac_code), 2048 - 2 + (CMAX - 1) * 4);

        // R4 R5: drive to the lower rail
        for (int i = 0; i < 1100; i++) cycle(-1, 1'b1, 1'b0, "R4 descend");
        check("R5 clamp low value", int'(dac_code), 0);
        cycle(0, 1'b1, 1'b0, "R4 lower rail exact");
        check("R4 lower rail output", int'(dac_code), 2048 + CMIN * 4);
        cycle(1, 1'b1, 1'b0, "R3 step up from low rail");
        check("R3 step up value", int'(dac_code), 2048 + 2 + (CMIN + 1) * 4);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule